// File: doc/BRIEF.md
# One-Wire Ratio-Coded Command Receiver

This block listens to a single enable line and takes in 24-bit write commands from a host. The host never sends a clock. Every bit lasts from one falling edge of the line to the next, and its value comes from how the low part of that interval compares with the high part. Because only the ratio matters, one receiver accepts hosts that run at very different bit rates.

A command is accepted only when all of the following hold:
- it follows a start condition;
- every bit meets a ratio rule;
- it carries the expected device address;
- it is closed by an end-of-stream interval.

An accepted command loads a 9-bit brightness code. If the command asks for it, the block also pulls the line low for a fixed time as an acknowledge. An invalid command is dropped and only raises a one-cycle error strobe.

The line input must already be synchronised to `clk`. All timing parameters are counted in clock cycles. The defaults assume a 10 MHz clock: 2 µs of start and end-of-stream time, a 4 µs acknowledge delay and a 256 µs acknowledge pulse. The acknowledge delay must be longer than the end-of-stream time.

Top module: `ratio_cmd_rx`

## Requirements
- R1: After reset, `level_o` is 0x1FF and `pull_o`, `cmd_valid_o` and `err_o` are all 0.
- R2: A bit is measured as L low samples followed by H high samples, counted from one falling edge to the next. It decodes as 0 when L >= 2*H and as 1 when H >= 2*L. Both bounds are inclusive.
- R3: A bit that meets neither rule in R2 makes the command invalid. At the end of the stream `err_o` pulses for one cycle, and `level_o` and `pull_o` stay unchanged.
- R4: Bits arrive least significant bit first, so the first bit received is bit 0. Bits 23..16 must equal 0x8F. Any other address makes the command invalid, with the same outcome as R3.
- R5: For a valid command, `level_o` takes bits 8..0, with bit 8 as the MSB. `cmd_valid_o` pulses for one cycle, visible EOS_CYC cycles after the sample that sees the final (25th) falling edge. Bits 15..11 and bit 9 are ignored. `level_o` changes at no other time.
- R6: After the final falling edge the line must stay low for the next EOS_CYC samples. If it rises earlier, the command is invalid (`err_o` pulses and `level_o` is kept).
- R7: A command is only recognised after the line has been high for at least START_CYC consecutive samples. A frame that starts earlier than that produces neither strobe and leaves `level_o` unchanged.
- R8: Bit 10 requests an acknowledge. When it is 1 and the command is valid, `pull_o` goes high ACK_DLY_CYC cycles after the final falling-edge sample and stays high for exactly ACK_LEN_CYC cycles. When bit 10 is 0, or the command is invalid, `pull_o` stays 0.
- R9: Bit periods from about 62 clock cycles up to 5880 clock cycles decode correctly. At 10 MHz this covers 160 kbit/s down to 1.7 kbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Synchronised level of the command line |
| pull_o | output | 1 | Pulls the line low (drives an open-drain stage) during an acknowledge |
| level_o | output | 9 | Stored brightness code |
| cmd_valid_o | output | 1 | One-cycle strobe when a valid command has been stored |
| err_o | output | 1 | One-cycle strobe when a received command is discarded |

## Verification
The end-of-stream decision and the host releasing the line can land on the same sample. The bench provokes this boundary from both sides.

In the first case, the line rises exactly on the EOS_CYC-th sample after the final edge. The command must then be rejected with `err_o` and no change to `level_o`. In the second case, the line rises one sample later. The command must then be accepted, and `cmd_valid_o` must appear on the very cycle in which the host lets go.

The acknowledge path is judged on the same timeline. Its start and length are counted from that final edge, while the host has already released the line.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int          CMD_BITS  = 24;
    localparam int          LEVEL_W   = 9;
    localparam int          ADDR_LSB  = 16;
    localparam int          ACKREQ_IX = 10;
    localparam logic [7:0]  DEV_ADDR  = 8'h8F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BIT,
        ST_EOS,
        ST_ACKWAIT,
        ST_PULL
    } rx_state_e;
endpackage

// File: rtl/rcr_ratio_judge.sv
module rcr_ratio_judge #(
    parameter int W = 16
) (
    input  logic [W-1:0] low_i,
    input  logic [W-1:0] high_i,
    output logic         is_zero_o,
    output logic         is_one_o
);
    // Compare against doubled counts without losing the carry bit.
    always_comb begin
        is_zero_o = ({1'b0, low_i}  >= {high_i, 1'b0});
        is_one_o  = ({1'b0, high_i} >= {low_i,  1'b0});
    end
endmodule

// File: rtl/rcr_frame_shift.sv
module rcr_frame_shift #(
    parameter int BITS = 24,
    localparam int CW  = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            shift_i,
    input  logic            bit_i,
    input  logic            bad_i,
    output logic [BITS-1:0] frame_o,
    output logic [CW-1:0]   count_o,
    output logic            bad_o
);
    typedef struct packed {
        logic [BITS-1:0] frame;
        logic [CW-1:0]   cnt;
        logic            bad;
    } fs_t;

    fs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.frame = '0;
            s_d.cnt   = '0;
            s_d.bad   = 1'b0;
        end else if (shift_i) begin
            // First bit received ends up at index 0 after BITS shifts.
            s_d.frame = {bit_i, s_q.frame[BITS-1:1]};
            s_d.cnt   = s_q.cnt + 1'b1;
            s_d.bad   = s_q.bad | bad_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frame_o = s_q.frame;
    assign count_o = s_q.cnt;
    assign bad_o   = s_q.bad;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(BITS)); // R4
endmodule

// File: rtl/ratio_cmd_rx.sv
module ratio_cmd_rx
    import rcr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int START_CYC   = 20,
    parameter int EOS_CYC     = 20,
    parameter int ACK_DLY_CYC = 40,
    parameter int ACK_LEN_CYC = 2560
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_i,
    output logic               pull_o,
    output logic [LEVEL_W-1:0] level_o,
    output logic               cmd_valid_o,
    output logic               err_o
);
    localparam int              NB_W     = $clog2(CMD_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] START_L  = CNT_W'(START_CYC);
    localparam logic [CNT_W-1:0] EOS_L1   = CNT_W'(EOS_CYC - 1);
    localparam logic [CNT_W-1:0] ADLY_L1  = CNT_W'(ACK_DLY_CYC - 1);
    localparam logic [CNT_W-1:0] ALEN_L1  = CNT_W'(ACK_LEN_CYC - 1);
    localparam logic [NB_W-1:0]  LAST_BIT = NB_W'(CMD_BITS - 1);

    typedef struct packed {
        rx_state_e          st;
        logic               prev;
        logic [CNT_W-1:0]   lo;
        logic [CNT_W-1:0]   hi;
        logic [CNT_W-1:0]   t;
        logic [LEVEL_W-1:0] level;
        logic               valid;
        logic               err;
        logic               pull;
    } rx_t;

    localparam rx_t RX_RST = '{
        st: ST_IDLE, prev: 1'b0, lo: '0, hi: '0, t: '0,
        level: '1, valid: 1'b0, err: 1'b0, pull: 1'b0
    };

    rx_t r_d, r_q;

    logic                is_zero, is_one;
    logic                fs_clr, fs_shift, fs_bit, fs_bad;
    logic [CMD_BITS-1:0] fs_frame;
    logic [NB_W-1:0]     fs_count;
    logic                fs_bad_q;
    logic                unused_rsv;

    assign unused_rsv = ^{fs_frame[15:11], fs_frame[9]};

    rcr_ratio_judge #(.W(CNT_W)) u_judge (
        .low_i    (r_q.lo),
        .high_i   (r_q.hi),
        .is_zero_o(is_zero),
        .is_one_o (is_one)
    );

    rcr_frame_shift #(.BITS(CMD_BITS)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (fs_clr),
        .shift_i(fs_shift),
        .bit_i  (fs_bit),
        .bad_i  (fs_bad),
        .frame_o(fs_frame),
        .count_o(fs_count),
        .bad_o  (fs_bad_q)
    );

    always_comb begin
        logic             fall;
        logic [CNT_W-1:0] lo_inc, hi_inc, t_sat, t_inc;
        logic             cmd_ok;

        fall   = r_q.prev & ~line_i;
        lo_inc = (r_q.lo == CNT_MAX) ? r_q.lo : r_q.lo + 1'b1;
        hi_inc = (r_q.hi == CNT_MAX) ? r_q.hi : r_q.hi + 1'b1;
        t_sat  = (r_q.t  == CNT_MAX) ? r_q.t  : r_q.t  + 1'b1;
        t_inc  = r_q.t + 1'b1;
        cmd_ok = !fs_bad_q && (fs_frame[ADDR_LSB +: 8] == DEV_ADDR);

        r_d       = r_q;
        r_d.prev  = line_i;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        fs_clr    = 1'b0;
        fs_shift  = 1'b0;
        fs_bit    = 1'b0;
        fs_bad    = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                // Count consecutive high samples until the start condition is met.
                if (line_i) begin
                    r_d.t = t_sat;
                    if (t_sat >= START_L) r_d.st = ST_ARMED;
                end else begin
                    r_d.t = '0;
                end
            end
            ST_ARMED: begin
                if (!line_i) begin
                    r_d.st = ST_BIT;
                    r_d.lo = CNT_W'(1);
                    r_d.hi = '0;
                    fs_clr = 1'b1;
                end
            end
            ST_BIT: begin
                if (fall) begin
                    // Falling edge closes the running bit and opens the next one.
                    fs_shift = 1'b1;
                    fs_bit   = is_one;
                    fs_bad   = !(is_zero || is_one);
                    r_d.lo   = CNT_W'(1);
                    r_d.hi   = '0;
                    if (fs_count == LAST_BIT) begin
                        r_d.st = ST_EOS;
                        r_d.t  = '0;
                    end
                end else if (!line_i) begin
                    r_d.lo = lo_inc;
                end else begin
                    r_d.hi = hi_inc;
                end
            end
            ST_EOS: begin
                if (line_i) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                    r_d.t   = '0;
                end else begin
                    r_d.t = t_inc;
                    if (r_q.t == EOS_L1) begin
                        if (cmd_ok) begin
                            r_d.level = fs_frame[LEVEL_W-1:0];
                            r_d.valid = 1'b1;
                            if (fs_frame[ACKREQ_IX]) begin
                                r_d.st = ST_ACKWAIT;
                            end else begin
                                r_d.st = ST_IDLE;
                                r_d.t  = '0;
                            end
                        end else begin
                            r_d.err = 1'b1;
                            r_d.st  = ST_IDLE;
                            r_d.t   = '0;
                        end
                    end
                end
            end
            ST_ACKWAIT: begin
                // The timer keeps running from the final falling edge.
                r_d.t = t_inc;
                if (r_q.t == ADLY_L1) begin
                    r_d.st   = ST_PULL;
                    r_d.t    = '0;
                    r_d.pull = 1'b1;
                end
            end
            ST_PULL: begin
                r_d.t = t_inc;
                if (r_q.t == ALEN_L1) begin
                    r_d.pull = 1'b0;
                    r_d.st   = ST_IDLE;
                    r_d.t    = '0;
                end
            end
            default: begin
                r_d = RX_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RX_RST;
        else        r_q <= r_d;
    end

    assign pull_o      = r_q.pull;
    assign level_o     = r_q.level;
    assign cmd_valid_o = r_q.valid;
    assign err_o       = r_q.err;

    // Length of the current run of pull cycles, used only by the checks below.
    logic [CNT_W:0] pull_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      pull_run_q <= '0;
        else if (pull_o) pull_run_q <= pull_run_q + 1'b1;
        else             pull_run_q <= '0;
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R5
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R3
    AST_LEVEL_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> cmd_valid_o); // R5
    AST_EOS_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EOS && line_i) |=> (err_o && !cmd_valid_o)); // R6
    AST_PULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        pull_o |-> (pull_run_q < (CNT_W+1)'(ACK_LEN_CYC))); // R8
    AST_NO_PULL_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !$rose(pull_o)); // R8
endmodule

// File: tb/tb_ratio_cmd_rx.sv
module tb_ratio_cmd_rx;
    localparam int CLK_PERIOD = 100;
    localparam int START = 20;
    localparam int EOS   = 20;
    localparam int ADLY  = 40;
    localparam int ALEN  = 2560;

    logic       clk    = 1'b0;
    logic       rst_n  = 1'b0;
    logic       m_line = 1'b0;
    logic       line;
    logic       pull;
    logic [8:0] level;
    logic       cv;
    logic       er;

    int n_chk  = 0;
    int n_fail = 0;
    int w_valid_k, w_err_k, w_pull_k, w_pull_n;

    // Open-drain line: the host and the block can both pull it low.
    assign line = m_line & ~pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    ratio_cmd_rx #(
        .CNT_W(16), .START_CYC(START), .EOS_CYC(EOS),
        .ACK_DLY_CYC(ADLY), .ACK_LEN_CYC(ALEN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .line_i(line), .pull_o(pull),
        .level_o(level), .cmd_valid_o(cv), .err_o(er)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input logic [7:0] addr, input logic ack, input logic [8:0] lvl);
        return {addr, 5'b0, ack, 1'b0, lvl};
    endfunction

    task automatic idle(input int n);
        m_line = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Sends 24 bits and leaves the line low after the final falling edge.
    task automatic send(input logic [23:0] f, input int zlo, input int zhi, input int olo,
                        input int ohi, input int bad_ix, input int bad_lo, input int bad_hi);
        for (int i = 0; i < 24; i++) begin
            int lo;
            int hi;
            lo = f[i] ? olo : zlo;
            hi = f[i] ? ohi : zhi;
            if (i == bad_ix) begin
                lo = bad_lo;
                hi = bad_hi;
            end
            m_line = 1'b0;
            repeat (lo) @(negedge clk);
            m_line = 1'b1;
            repeat (hi) @(negedge clk);
        end
        m_line = 1'b0;
    endtask

    // k counts cycles after the final edge; the host releases the line at k == rel.
    task automatic watch(input int rel, input int n);
        w_valid_k = -1;
        w_err_k   = -1;
        w_pull_k  = -1;
        w_pull_n  = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (cv && w_valid_k < 0) w_valid_k = k;
            if (er && w_err_k < 0)   w_err_k = k;
            if (pull) begin
                if (w_pull_k < 0) w_pull_k = k;
                w_pull_n++;
            end
            if (k == rel) m_line = 1'b1;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", "level after reset", int'(level), 'h1FF);
        chk("R1", "pull after reset", int'(pull), 0);
        chk("R1", "valid strobe after reset", int'(cv), 0);
        chk("R1", "error strobe after reset", int'(er), 0);
    endtask

    task automatic t_no_start;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        idle(START - 1);
        send(mk(8'h8F, 1'b0, 9'h055), 16, 8, 8, 16, -1, 0, 0);
        watch(EOS + 1, 60);
        chk("R7", "valid without start", w_valid_k, -1);
        chk("R7", "error without start", w_err_k, -1);
        chk("R7", "level without start", int'(level), 'h1FF);
    endtask

    task automatic t_valid_fast;
        idle(40);
        send(mk(8'h8F, 1'b0, 9'h0A5), 45, 15, 15, 45, -1, 0, 0);
        watch(EOS + 1, 80);
        chk("R5", "valid strobe cycle", w_valid_k, EOS + 1);
        chk("R5", "level after valid", int'(level), 'h0A5);
        chk("R6", "no error when released after window", w_err_k, -1);
        chk("R8", "no pull without request", w_pull_n, 0);
        chk("R9", "fast rate level", int'(level), 'h0A5);
    endtask

    task automatic t_ratio_edge;
        idle(40);
        send(mk(8'h8F, 1'b0, 9'h15A), 42, 21, 21, 42, -1, 0, 0);
        watch(EOS + 1, 60);
        chk("R2", "exact 2:1 ratios valid", w_valid_k, EOS + 1);
        chk("R2", "exact 2:1 ratios level", int'(level), 'h15A);
    endtask

    task automatic t_bad_ratio;
        idle(40);
        send(mk(8'h8F, 1'b1, 9'h001), 45, 15, 15, 45, 3, 30, 20);
        watch(EOS + 1, 120);
        chk("R3", "error strobe cycle", w_err_k, EOS + 1);
        chk("R3", "no valid strobe", w_valid_k, -1);
        chk("R3", "level kept", int'(level), 'h15A);
        chk("R3", "no ack on bad bit", w_pull_n, 0);
    endtask

    task automatic t_bad_addr;
        idle(40);
        send(mk(8'h8E, 1'b1, 9'h002), 45, 15, 15, 45, -1, 0, 0);
        watch(EOS + 1, 120);
        chk("R4", "error on wrong address", w_err_k, EOS + 1);
        chk("R4", "level kept on wrong address", int'(level), 'h15A);
        chk("R8", "no ack on wrong address", w_pull_n, 0);
    endtask

    task automatic t_ack;
        idle(40);
        send(mk(8'h8F, 1'b1, 9'h033) | 24'h001200, 45, 15, 15, 45, -1, 0, 0);
        watch(EOS + 1, ADLY + ALEN + 20);
        chk("R5", "reserved bits ignored, valid", w_valid_k, EOS + 1);
        chk("R5", "level with reserved bits set", int'(level), 'h033);
        chk("R8", "ack start cycle", w_pull_k, ADLY + 1);
        chk("R8", "ack length", w_pull_n, ALEN);
        chk("R8", "pull released", int'(pull), 0);
    endtask

    task automatic t_eos_break;
        idle(40);
        send(mk(8'h8F, 1'b0, 9'h1C3), 45, 15, 15, 45, -1, 0, 0);
        watch(EOS, 60);
        chk("R6", "error on early release", w_err_k, EOS + 1);
        chk("R6", "no valid on early release", w_valid_k, -1);
        chk("R6", "level kept on early release", int'(level), 'h033);
    endtask

    task automatic t_slow;
        idle(40);
        send(mk(8'h8F, 1'b0, 9'h100), 3920, 1960, 1960, 3920, -1, 0, 0);
        watch(EOS + 1, 60);
        chk("R9", "slow rate valid", w_valid_k, EOS + 1);
        chk("R9", "slow rate level", int'(level), 'h100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset;
        t_no_start;
        t_valid_fast;
        t_ratio_edge;
        t_bad_ratio;
        t_bad_addr;
        t_ack;
        t_eos_break;
        t_slow;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule